// File: doc/BRIEF.md
# Legacy Port-Input Permission and Address Mapper

This block takes one legacy port-input request at a time and decides whether it may proceed. It builds the 16-bit port number from either an 8-bit immediate or a 16-bit register value, and it decodes the access width from the opcode and an operand-size input. From the privilege and mode inputs it works out whether the per-port permission bitmap must be consulted. When the bitmap is not needed, the block answers in the next cycle. When it is needed, the block reads the bitmap through a synchronous read port and answers two cycles later.

Each answer is either a general-protection fault or a 64-bit virtual address with a size code. The address places four ports in each 4 KB page above a programmable base. A fault is also raised when data translation is off or when the address is flagged as unimplemented. Both of those conditions are merged with the bitmap verdict.

Requests use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and all request inputs are sampled only on that edge. While a bitmap read is in flight, `req_ready` stays low and the requester must hold or withdraw its request. The response side has no back-pressure: `rsp_valid` is high for exactly one cycle per accepted request, and the fields beside it are meaningful only in that cycle.

Top module: `ioperm_unit`

## Requirements
- R1: Opcode bit 3 selects the port source. Bit 3 = 0 (E4/E5) uses the immediate, with port bits [15:8] forced to zero. Bit 3 = 1 (EC/ED) uses the full 16-bit `req_dx`.
- R2: `rsp_size` encodes the width as 0 = 8 bits, 1 = 16 bits and 2 = 32 bits. Opcode bit 0 = 0 gives 0. Opcode bit 0 = 1 gives 2 when `req_op32` is 1 and 1 otherwise. The value 3 never appears.
- R3: The bitmap is read only when `pe`=1, `io_chk`=1, and either `vm`=1 or `cpl` > `iopl`. Otherwise there is no read, and `rsp_valid` rises in the cycle after acceptance.
- R4: When the bitmap is needed, `bm_rd_en` is high for the single cycle after acceptance, with `bm_rd_addr` equal to port[15:4]. `bm_rd_data` is taken in the following cycle, and `rsp_valid` rises the cycle after that.
- R5: `bm_rd_data[15:0]` holds the 16-bit bitmap word at `bm_rd_addr`, and `bm_rd_data[31:16]` holds the next word. Bit p of the bitmap belongs to port p. The access faults if any bit from port through port+N-1 is 1, where N is 1, 2 or 4. This covers the case where that span crosses into the next word.
- R6: The response faults when `xlate_en`=0 or `addr_unimpl`=1, on either path. On the bitmap path this fault is ORed with the bitmap verdict.
- R7: `rsp_vaddr` = `io_base` OR (port[15:2] << 12) OR port[11:0].
- R8: `req_ready` is low from the edge that accepts a bitmap request until the response cycle. A request presented while busy is neither taken nor answered. A bitmap-free request may be taken on every edge, which gives one response per cycle.
- R9: After reset, `req_ready`=1, `rsp_valid`=0 and `bm_rd_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_opcode | input | 8 | Opcode byte (E4, E5, EC, ED) |
| req_imm | input | 8 | Immediate port number |
| req_dx | input | 16 | Register port number |
| req_op32 | input | 1 | Operand size is 32 bits for wide opcodes |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| pe | input | 1 | Protected mode on |
| vm | input | 1 | Virtual-8086 mode on |
| io_chk | input | 1 | Bitmap checking enabled |
| xlate_en | input | 1 | Data translation enabled |
| addr_unimpl | input | 1 | Mapped address is unimplemented |
| io_base | input | 64 | Base of the port-mapped virtual region |
| bm_rd_en | output | 1 | Bitmap read request |
| bm_rd_addr | output | 12 | Bitmap word index |
| bm_rd_data | input | 32 | Bitmap words at index and index+1, one cycle after the read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | General-protection fault |
| rsp_vaddr | output | 64 | Translated virtual address |
| rsp_size | output | 2 | Width code |

## Verification
A bitmap-free request is answered one cycle after its accepting edge. A bitmap request raises the read strobe one cycle after acceptance and is answered three cycles after acceptance. The bench therefore drives inputs and samples outputs on the falling edge. For each request it checks the expected output in every cycle from acceptance to response. It presents the bitmap word only after the edge that follows the read strobe, so a design that takes the data one cycle early will not see the word it expects.

// File: rtl/ioperm_pkg.sv
package ioperm_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } size_code_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WT   = 2'd2
  } io_state_t;

  function automatic logic [3:0] span_mask(input size_code_t sz);
    case (sz)
      SZ_BYTE:  span_mask = 4'b0001;
      SZ_WORD:  span_mask = 4'b0011;
      default:  span_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/ioperm_decode.sv
module ioperm_decode
  import ioperm_pkg::*;
#(
  parameter int PORT_W     = 16,
  parameter int VA_W       = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int PPP_LG     = 2
) (
  input  logic [7:0]        opcode,
  input  logic [7:0]        imm,
  input  logic [PORT_W-1:0] dx,
  input  logic              op32,
  input  logic [1:0]        cpl,
  input  logic [1:0]        iopl,
  input  logic              pe,
  input  logic              vm,
  input  logic              io_chk,
  input  logic [VA_W-1:0]   io_base,
  output logic [PORT_W-1:0] port,
  output size_code_t        size,
  output logic              need_bm,
  output logic [VA_W-1:0]   vaddr
);
  localparam int PG_BITS = PORT_W - PPP_LG;

  logic [VA_W-1:0] page_part;
  logic [VA_W-1:0] off_part;

  always_comb begin
    port = opcode[3] ? dx : {{(PORT_W-8){1'b0}}, imm};
    if (!opcode[0])  size = SZ_BYTE;
    else if (op32)   size = SZ_DWORD;
    else             size = SZ_WORD;
    need_bm   = pe && io_chk && (vm || (cpl > iopl));
    page_part = VA_W'(port[PORT_W-1 -: PG_BITS]) << PAGE_SHIFT;
    off_part  = VA_W'(port[PAGE_SHIFT-1:0]);
    vaddr     = io_base | page_part | off_part;
  end
endmodule

// File: rtl/ioperm_bmcheck.sv
module ioperm_bmcheck
  import ioperm_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int WORD_W = 16
) (
  input  logic [PORT_W-1:0]        port,
  input  size_code_t               size,
  input  logic [2*WORD_W-1:0]      words,
  output logic [PORT_W-$clog2(WORD_W)-1:0] word_idx,
  output logic                     hit
);
  localparam int WLG = $clog2(WORD_W);

  logic [2*WORD_W-1:0] window;

  always_comb begin
    word_idx = port[PORT_W-1:WLG];
    window   = words >> port[WLG-1:0];
    hit      = |(window[3:0] & span_mask(size));
  end
endmodule

// File: rtl/ioperm_unit.sv
module ioperm_unit
  import ioperm_pkg::*;
#(
  parameter int PORT_W     = 16,
  parameter int VA_W       = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int PPP_LG     = 2,
  parameter int WORD_W     = 16,
  localparam int AW        = PORT_W - $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_opcode,
  input  logic [7:0]        req_imm,
  input  logic [PORT_W-1:0] req_dx,
  input  logic              req_op32,
  input  logic [1:0]        cpl,
  input  logic [1:0]        iopl,
  input  logic              pe,
  input  logic              vm,
  input  logic              io_chk,
  input  logic              xlate_en,
  input  logic              addr_unimpl,
  input  logic [VA_W-1:0]   io_base,
  output logic              bm_rd_en,
  output logic [AW-1:0]     bm_rd_addr,
  input  logic [2*WORD_W-1:0] bm_rd_data,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [VA_W-1:0]   rsp_vaddr,
  output logic [1:0]        rsp_size
);
  io_state_t         state;
  logic [PORT_W-1:0] dec_port, lat_port;
  size_code_t        dec_size, lat_size;
  logic              dec_need;
  logic [VA_W-1:0]   dec_vaddr, lat_vaddr;
  logic              lat_xfault;
  logic              bm_hit;
  logic              accept;

  ioperm_decode #(.PORT_W(PORT_W), .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .PPP_LG(PPP_LG)) u_dec (
    .opcode(req_opcode), .imm(req_imm), .dx(req_dx), .op32(req_op32),
    .cpl(cpl), .iopl(iopl), .pe(pe), .vm(vm), .io_chk(io_chk), .io_base(io_base),
    .port(dec_port), .size(dec_size), .need_bm(dec_need), .vaddr(dec_vaddr)
  );

  ioperm_bmcheck #(.PORT_W(PORT_W), .WORD_W(WORD_W)) u_bm (
    .port(lat_port), .size(lat_size), .words(bm_rd_data),
    .word_idx(bm_rd_addr), .hit(bm_hit)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign bm_rd_en  = (state == ST_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      lat_port   <= '0;
      lat_size   <= SZ_BYTE;
      lat_vaddr  <= '0;
      lat_xfault <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_vaddr  <= '0;
      rsp_size   <= 2'd0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (dec_need) begin
            lat_port   <= dec_port;
            lat_size   <= dec_size;
            lat_vaddr  <= dec_vaddr;
            lat_xfault <= !xlate_en || addr_unimpl;
            state      <= ST_RD;
          end else begin
            rsp_valid <= 1'b1;
            rsp_fault <= !xlate_en || addr_unimpl;
            rsp_vaddr <= dec_vaddr;
            rsp_size  <= dec_size;
          end
        end
        ST_RD: state <= ST_WT;
        ST_WT: begin
          rsp_valid <= 1'b1;
          rsp_fault <= lat_xfault || bm_hit;
          rsp_vaddr <= lat_vaddr;
          rsp_size  <= lat_size;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r3_direct_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec_need) |=> (rsp_valid && !bm_rd_en));
  a_r4_read_then_resp: assert property (@(posedge clk) disable iff (!rst_n)
    bm_rd_en |=> ##1 rsp_valid);
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    bm_rd_en |-> !req_ready);
  a_r2_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_size != 2'd3));
  a_r6_xlate_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec_need && (!xlate_en || addr_unimpl)) |=> rsp_fault);
endmodule

// File: tb/sim_ioperm_unit.sv
`timescale 1ns/1ps
module sim_ioperm_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_opcode = 8'hE4;
  logic [7:0]  req_imm = 8'h00;
  logic [15:0] req_dx = 16'h0000;
  logic        req_op32 = 1'b0;
  logic [1:0]  cpl = 2'd0, iopl = 2'd0;
  logic        pe = 1'b0, vm = 1'b0, io_chk = 1'b0, xlate_en = 1'b1, addr_unimpl = 1'b0;
  logic [63:0] io_base = 64'hFFFF_8000_0000_0000;
  logic        bm_rd_en;
  logic [11:0] bm_rd_addr;
  logic [31:0] bm_rd_data = 32'h0;
  logic        rsp_valid, rsp_fault;
  logic [63:0] rsp_vaddr;
  logic [1:0]  rsp_size;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ioperm_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_imm(req_imm), .req_dx(req_dx), .req_op32(req_op32),
    .cpl(cpl), .iopl(iopl), .pe(pe), .vm(vm), .io_chk(io_chk), .xlate_en(xlate_en),
    .addr_unimpl(addr_unimpl), .io_base(io_base), .bm_rd_en(bm_rd_en),
    .bm_rd_addr(bm_rd_addr), .bm_rd_data(bm_rd_data), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_vaddr(rsp_vaddr), .rsp_size(rsp_size)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [7:0]  imm;
    logic [15:0] dx;
    logic        op32;
    logic [1:0]  cpl;
    logic [1:0]  iopl;
    logic        pe, vm, ioc, xl, un;
    logic [31:0] bm;
    logic        need, fault;
    logic [1:0]  size;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{8'hE4, 8'h60, 16'h0000, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 2'd0},
    '{8'hEC, 8'h00, 16'h1234, 1'b0, 2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0010, 1'b1, 1'b1, 2'd0},
    '{8'hED, 8'h00, 16'h03F8, 1'b1, 2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_F0FF, 1'b1, 1'b0, 2'd2},
    '{8'hED, 8'h00, 16'h100F, 1'b0, 2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0001_0000, 1'b1, 1'b1, 2'd1},
    '{8'hE5, 8'hFE, 16'hFFFF, 1'b1, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFC_3FFF, 1'b1, 1'b0, 2'd2},
    '{8'hED, 8'h00, 16'h0040, 1'b1, 2'd3, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 2'd2},
    '{8'hEC, 8'h00, 16'h5555, 1'b0, 2'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 2'd0},
    '{8'hE4, 8'h80, 16'h1111, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 1'b1, 2'd0},
    '{8'hEC, 8'h00, 16'hFFFF, 1'b0, 2'd2, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b1, 2'd0},
    '{8'hE5, 8'h21, 16'h0000, 1'b0, 2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFF9, 1'b1, 1'b0, 2'd1},
    '{8'hED, 8'h00, 16'hABCD, 1'b1, 2'd0, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_8000, 1'b1, 1'b1, 2'd2}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] port_of(input vec_t v);
    return v.op[3] ? v.dx : {8'h00, v.imm};
  endfunction

  function automatic logic [63:0] va_of(input logic [15:0] p);
    return io_base | ({50'd0, p[15:2]} << 12) | {52'd0, p[11:0]};
  endfunction

  task automatic apply(input vec_t v);
    req_opcode = v.op; req_imm = v.imm; req_dx = v.dx; req_op32 = v.op32;
    cpl = v.cpl; iopl = v.iopl; pe = v.pe; vm = v.vm; io_chk = v.ioc;
    xlate_en = v.xl; addr_unimpl = v.un;
  endtask

  task automatic check_rsp(input string tag, input vec_t v);
    chk({tag, " R3/R4 rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " R5/R6 fault"}, 64'(rsp_fault), 64'(v.fault));
    chk({tag, " R2 size"}, 64'(rsp_size), 64'(v.size));
    chk({tag, " R1/R7 vaddr"}, rsp_vaddr, va_of(port_of(v)));
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    apply(v);
    req_valid = 1'b1;
    chk("R8 ready when idle", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (v.need) begin
      chk("R4 read strobe", 64'(bm_rd_en), 64'd1);
      chk("R4 read addr", 64'(bm_rd_addr), 64'(port_of(v) >> 4));
      chk("R8 busy not ready", 64'(req_ready), 64'd0);
      @(posedge clk);
      #1 bm_rd_data = v.bm;
      @(negedge clk);
      chk("R4 no early rsp", 64'(rsp_valid), 64'd0);
      chk("R4 single strobe", 64'(bm_rd_en), 64'd0);
      @(posedge clk);
      #1 bm_rd_data = 32'h0;
      @(negedge clk);
      check_rsp("bitmap", v);
    end else begin
      chk("R3 no read", 64'(bm_rd_en), 64'd0);
      check_rsp("direct", v);
    end
    @(negedge clk);
    chk("R8 one response", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R9 reset ready", 64'(req_ready), 64'd1);
    chk("R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R9 reset bm_rd_en", 64'(bm_rd_en), 64'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R8: back-to-back bitmap-free requests, one response per cycle
    @(negedge clk);
    apply(VEC[0]); req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_rsp("b2b first", VEC[0]);
    apply(VEC[5]);
    chk("R8 ready during rsp", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("b2b second", VEC[5]);

    // R8: request held while busy is ignored
    @(negedge clk);
    apply(VEC[2]); req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    apply(VEC[7]);
    chk("R8 busy ignores RD", 64'(req_ready), 64'd0);
    @(posedge clk);
    #1 bm_rd_data = VEC[2].bm;
    @(negedge clk);
    chk("R8 busy ignores WT", 64'(req_ready), 64'd0);
    chk("R8 no rsp while busy", 64'(rsp_valid), 64'd0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    bm_rd_data = 32'h0;
    check_rsp("busy owner", VEC[2]);
    @(negedge clk);
    chk("R8 held request not answered", 64'(rsp_valid), 64'd0);

    // R9: reset while busy returns to idle
    @(negedge clk);
    apply(VEC[1]); req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R9 reset mid-read ready", 64'(req_ready), 64'd1);
    chk("R9 reset mid-read strobe", 64'(bm_rd_en), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 no rsp after reset", 64'(rsp_valid), 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule